// File: doc/BRIEF.md
# Skip and Prefix Sequencer

This block controls instruction flow for a small 8-bit accumulator core. Fetched program bytes arrive one at a time. The block works out where each instruction starts and ends, and tags every byte on its way to the execute stage. Each byte gets a first/last marker and a squash flag. A squashed byte belongs to an instruction that must not take effect. Each byte also carries an operand-address override. When the override is set, the datapath uses the given 8-bit RAM address in place of the `[B]` pointer.

Three kinds of instruction decide whether the next instruction is squashed:

- Conditional tests skip their successor when the condition fails.
- The decrement-register-and-skip group skips when the decremented value reaches zero.
- Return-with-skip always skips.

The two-byte direct-addressing prefix (opcode 0xBD plus an address byte) sets the override for the one instruction that follows it. A skip treats a prefix and the instruction it modifies as one unit.

The datapath reports the outcome of a test on `cond_met`, sampled together with the final byte of that instruction. Each tagged byte appears on the outputs one clock after it is accepted.

Top module: `skip_prefix_seq`

## Requirements
- R1: Instruction length follows from the opcode. Three bytes: 0xA9, 0xAC, 0xAD, 0xBC. Two bytes: 0x20–0x3F, 0x60, 0x61, 0x90–0x9F, 0xBD, 0xD0–0xDF. All other opcodes are one byte. `ob_first` marks the opcode byte and `ob_last` marks the final byte. Operand bytes are never decoded as opcodes.
- R2: Each byte accepted with `fb_valid` high produces exactly one output record on the next cycle, with `ob_valid` high and `ob_byte` equal to the byte. When no byte is accepted, `ob_valid` is low.
- R3: The test opcodes are 0x40–0x4F, 0x60, 0x70–0x77, 0x82, 0x83, 0x88, 0x89, 0x92, 0x93, 0x99, 0xA9 and 0xB9. When one of them completes with `cond_met` low, the next instruction is squashed. With `cond_met` high, the next instruction runs.
- R4: An opcode in 0xC0–0xCF that completes with `cond_met` high (result zero) squashes the next instruction. With `cond_met` low, the next instruction runs.
- R5: Opcode 0x8D squashes the next instruction whatever the value of `cond_met`.
- R6: A squashed instruction has `ob_squash` high on all of its bytes. Its own skip outcome is discarded, so it never squashes its successor.
- R7: A prefix that is not squashed has `ob_prefix` high and `ovr_valid` low on both of its bytes. Its second byte becomes `ovr_addr`, and `ovr_valid` is high on every byte of the next non-prefix instruction. When `ovr_valid` is low, `ovr_addr` reads zero.
- R8: The override covers exactly one instruction. The instruction after the one it modified has `ovr_valid` low.
- R9: When prefixes follow one another, the address from the most recent prefix is used.
- R10: If the instruction to be squashed is a prefix, the prefix and the instruction after it are both squashed. This also holds across a chain of prefixes. A squashed prefix does not set the override.
- R11: Synchronous reset (`rst` high) clears a pending skip, a pending override and a partly received instruction. The first byte accepted after reset is decoded as an opcode.
- R12: Cycles with `fb_valid` low, including gaps inside a multi-byte instruction, leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_valid | input | 1 | A program byte is presented this cycle |
| fb_byte | input | 8 | Program byte |
| cond_met | input | 1 | Test outcome, sampled with the final byte of an instruction |
| ob_valid | output | 1 | Tagged byte record is valid |
| ob_byte | output | 8 | The tagged program byte |
| ob_first | output | 1 | Byte is an opcode |
| ob_last | output | 1 | Byte ends its instruction |
| ob_squash | output | 1 | Byte belongs to a skipped instruction |
| ob_prefix | output | 1 | Byte belongs to an address-override prefix |
| ovr_valid | output | 1 | Operand override applies to this instruction |
| ovr_addr | output | 8 | Override RAM address (zero when not valid) |

## Verification
The bench hides prefix opcodes and test opcodes inside the operand bytes of a skipped three-byte jump. A length decoder that slipped would then report a spurious prefix or a new skip. It skips over a prefix, and over a chain of two prefixes, to check that a design skipping only the prefix would not let the modified instruction run. It also checks that the address of a squashed prefix never leaks to a later instruction. It skips a failing test that is itself squashed, and a return-with-skip whose condition input is low: a design that read either outcome would squash one instruction too many or too few. Reset arrives in the middle of an instruction, and gaps occur inside instructions, to expose framing state that is not held or not cleared.

// File: rtl/skipseq_pkg.sv
`timescale 1ns/1ps
package skipseq_pkg;

    localparam int BYTE_W = 8;
    localparam int LEN_W  = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LEN_W-1:0]  len_t;

    localparam byte_t PREFIX_OPC = 8'hBD;
    localparam len_t  LEN_ONE    = len_t'(1);
    localparam len_t  LEN_TWO    = len_t'(2);
    localparam len_t  LEN_THREE  = len_t'(3);

    typedef enum logic [2:0] {
        K_PLAIN   = 3'd0,
        K_TEST    = 3'd1,
        K_DECSKIP = 3'd2,
        K_RETSKIP = 3'd3,
        K_PREFIX  = 3'd4
    } kind_e;

    typedef struct packed {
        len_t  len;
        kind_e kind;
    } dec_t;

    typedef struct packed {
        logic  valid;
        byte_t data;
        logic  first;
        logic  last;
        logic  squash;
        logic  prefix;
        logic  ovr_v;
        byte_t ovr_addr;
    } out_rec_t;

    // Length and flow class of an opcode byte; first matching arm wins.
    function automatic dec_t decode_op(input byte_t op);
        dec_t d;
        d.len  = LEN_ONE;
        d.kind = K_PLAIN;
        casez (op)
            8'b0010_????,
            8'b0011_????: d.len = LEN_TWO;
            8'b0100_????: d.kind = K_TEST;
            8'h60:        begin d.len = LEN_TWO; d.kind = K_TEST; end
            8'h61:        d.len = LEN_TWO;
            8'b0111_0???: d.kind = K_TEST;
            8'h82, 8'h83,
            8'h88, 8'h89: d.kind = K_TEST;
            8'h8D:        d.kind = K_RETSKIP;
            8'h92, 8'h93,
            8'h99:        begin d.len = LEN_TWO; d.kind = K_TEST; end
            8'b1001_????: d.len = LEN_TWO;
            8'hA9:        begin d.len = LEN_THREE; d.kind = K_TEST; end
            8'hAC, 8'hAD,
            8'hBC:        d.len = LEN_THREE;
            8'hB9:        d.kind = K_TEST;
            PREFIX_OPC:   begin d.len = LEN_TWO; d.kind = K_PREFIX; end
            8'b1100_????: d.kind = K_DECSKIP;
            8'b1101_????: d.len = LEN_TWO;
            default:      ;
        endcase
        return d;
    endfunction

    // Whether a completed, non-squashed instruction skips its successor.
    function automatic logic skip_verdict(input kind_e k, input logic cond);
        case (k)
            K_TEST:    return !cond;
            K_DECSKIP: return cond;
            K_RETSKIP: return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/skipseq_framer.sv
`timescale 1ns/1ps
module skipseq_framer
    import skipseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  byte_t in_byte,
    output logic  is_start,
    output logic  is_end,
    output kind_e kind
);
    dec_t  dec_now;
    len_t  rem_q;
    kind_e kind_q;

    always_comb dec_now = decode_op(in_byte);

    // rem_q counts operand bytes still owed by the current instruction.
    assign is_start = (rem_q == '0);
    assign is_end   = is_start ? (dec_now.len == LEN_ONE) : (rem_q == LEN_ONE);
    assign kind     = is_start ? dec_now.kind : kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            kind_q <= K_PLAIN;
        end else if (in_valid) begin
            if (is_start) begin
                rem_q  <= dec_now.len - LEN_ONE;
                kind_q <= dec_now.kind;
            end else begin
                rem_q  <= rem_q - LEN_ONE;
            end
        end
    end

    p_tail_bounded_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_start) |-> (rem_q <= LEN_TWO));

    p_tail_steps_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_start && !is_end) |=> (rem_q == LEN_ONE));

    p_hold_on_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(rem_q));

endmodule

// File: rtl/skipseq_skip.sv
`timescale 1ns/1ps
module skipseq_skip
    import skipseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  is_start,
    input  logic  is_end,
    input  kind_e kind,
    input  logic  cond_met,
    output logic  squash
);
    logic skip_q;   // the next instruction must be squashed
    logic pair_q;   // a squashed prefix drags its successor along
    logic sq_q;     // squash state of the instruction in flight
    logic squash_new;

    assign squash_new = skip_q | pair_q;
    assign squash     = is_start ? squash_new : sq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_q <= 1'b0;
            pair_q <= 1'b0;
            sq_q   <= 1'b0;
        end else if (in_valid) begin
            if (is_start) begin
                sq_q   <= squash_new;
                pair_q <= squash_new && (kind == K_PREFIX);
                if (squash_new) skip_q <= 1'b0;
            end
            if (is_end && !squash) begin
                skip_q <= skip_verdict(kind, cond_met);
            end
        end
    end

    p_pair_from_prefix_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(pair_q) |-> $past(in_valid && is_start && kind == K_PREFIX));

    p_pend_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(skip_q && pair_q));

    p_squashed_no_verdict_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_end && squash && !is_start) |=> !skip_q);

endmodule

// File: rtl/skipseq_ovr.sv
`timescale 1ns/1ps
module skipseq_ovr
    import skipseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  is_start,
    input  logic  is_end,
    input  kind_e kind,
    input  logic  squash,
    input  byte_t in_byte,
    output logic  ovr_v,
    output byte_t ovr_addr
);
    logic  arm_q;        // an override waits for the next instruction
    byte_t arm_addr_q;
    logic  act_q;        // override applies to the instruction in flight
    byte_t act_addr_q;
    logic  take_now;

    assign take_now = arm_q && (kind != K_PREFIX) && !squash;
    assign ovr_v    = is_start ? take_now : act_q;
    assign ovr_addr = ovr_v ? (is_start ? arm_addr_q : act_addr_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q      <= 1'b0;
            arm_addr_q <= '0;
            act_q      <= 1'b0;
            act_addr_q <= '0;
        end else if (in_valid) begin
            if (is_start) begin
                act_q      <= take_now;
                act_addr_q <= arm_addr_q;
                if (kind != K_PREFIX) arm_q <= 1'b0;
            end
            if ((kind == K_PREFIX) && is_end && !squash) begin
                arm_q      <= 1'b1;
                arm_addr_q <= in_byte;
            end
        end
    end

    p_arm_from_prefix_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(arm_q) |-> $past(in_valid && kind == K_PREFIX && !squash));

    p_single_use_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_start && kind != K_PREFIX) |=> !arm_q);

endmodule

// File: rtl/skip_prefix_seq.sv
`timescale 1ns/1ps
module skip_prefix_seq
    import skipseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fb_valid,
    input  logic [7:0] fb_byte,
    input  logic       cond_met,
    output logic       ob_valid,
    output logic [7:0] ob_byte,
    output logic       ob_first,
    output logic       ob_last,
    output logic       ob_squash,
    output logic       ob_prefix,
    output logic       ovr_valid,
    output logic [7:0] ovr_addr
);
    logic     is_start, is_end, squash, ov_v;
    kind_e    kind;
    byte_t    ov_addr;
    out_rec_t rec_q;

    skipseq_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .in_valid (fb_valid),
        .in_byte  (fb_byte),
        .is_start (is_start),
        .is_end   (is_end),
        .kind     (kind)
    );

    skipseq_skip u_skip (
        .clk      (clk),
        .rst      (rst),
        .in_valid (fb_valid),
        .is_start (is_start),
        .is_end   (is_end),
        .kind     (kind),
        .cond_met (cond_met),
        .squash   (squash)
    );

    skipseq_ovr u_ovr (
        .clk      (clk),
        .rst      (rst),
        .in_valid (fb_valid),
        .is_start (is_start),
        .is_end   (is_end),
        .kind     (kind),
        .squash   (squash),
        .in_byte  (fb_byte),
        .ovr_v    (ov_v),
        .ovr_addr (ov_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else begin
            rec_q.valid    <= fb_valid;
            rec_q.data     <= fb_byte;
            rec_q.first    <= is_start;
            rec_q.last     <= is_end;
            rec_q.squash   <= squash;
            rec_q.prefix   <= (kind == K_PREFIX);
            rec_q.ovr_v    <= ov_v;
            rec_q.ovr_addr <= ov_addr;
        end
    end

    assign ob_valid  = rec_q.valid;
    assign ob_byte   = rec_q.data;
    assign ob_first  = rec_q.first;
    assign ob_last   = rec_q.last;
    assign ob_squash = rec_q.squash;
    assign ob_prefix = rec_q.prefix;
    assign ovr_valid = rec_q.ovr_v;
    assign ovr_addr  = rec_q.ovr_addr;

    // Output-side history used only by the assertions below.
    logic  hist_closed, hist_sq, hist_ov;
    byte_t hist_addr;
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_closed <= 1'b1;
            hist_sq     <= 1'b0;
            hist_ov     <= 1'b0;
            hist_addr   <= '0;
        end else if (ob_valid) begin
            hist_closed <= ob_last;
            hist_sq     <= ob_squash;
            hist_ov     <= ovr_valid;
            hist_addr   <= ovr_addr;
        end
    end

    p_frame_order_r1: assert property (@(posedge clk) disable iff (rst)
        (ob_valid && ob_first) |-> hist_closed);

    p_whole_squash_r6: assert property (@(posedge clk) disable iff (rst)
        (ob_valid && !ob_first) |-> (ob_squash == hist_sq));

    p_ovr_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (ob_valid && !ob_first) |-> (ovr_valid == hist_ov && ovr_addr == hist_addr));

    p_prefix_bare_r7: assert property (@(posedge clk) disable iff (rst)
        (ob_valid && ob_prefix) |-> !ovr_valid);

endmodule

// File: tb/skip_prefix_seq_test.sv
`timescale 1ns/1ps
module skip_prefix_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fb_valid = 1'b0;
    logic [7:0] fb_byte = 8'h00;
    logic       cond_met = 1'b0;
    logic       ob_valid, ob_first, ob_last, ob_squash, ob_prefix, ovr_valid;
    logic [7:0] ob_byte, ovr_addr;

    always #4 clk = ~clk;

    skip_prefix_seq uut (
        .clk       (clk),
        .rst       (rst),
        .fb_valid  (fb_valid),
        .fb_byte   (fb_byte),
        .cond_met  (cond_met),
        .ob_valid  (ob_valid),
        .ob_byte   (ob_byte),
        .ob_first  (ob_first),
        .ob_last   (ob_last),
        .ob_squash (ob_squash),
        .ob_prefix (ob_prefix),
        .ovr_valid (ovr_valid),
        .ovr_addr  (ovr_addr)
    );

    typedef struct packed {
        logic [7:0] data;
        logic       first;
        logic       last;
        logic       sq;
        logic       pf;
        logic       ov;
        logic [7:0] addr;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    in_rst = 1'b1;
    bit    done   = 1'b0;

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: pop and compare each record the design produces.
    always @(negedge clk) begin
        if (!in_rst && !done && ob_valid) begin
            exp_t got;
            got = {ob_byte, ob_first, ob_last, ob_squash, ob_prefix, ovr_valid, ovr_addr};
            n_cmp++;
            if (expq.size() == 0) begin
                n_bad++;
                $display("FAIL R2: unexpected record got=%h expected=none", got);
            end else begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                if (got !== e) begin
                    n_bad++;
                    $display("FAIL %s: got=%h expected=%h", t, got, e);
                end
            end
        end
    end

    task automatic put(input logic [7:0] b, input logic c);
        @(negedge clk);
        fb_valid = 1'b1;
        fb_byte  = b;
        cond_met = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fb_valid = 1'b0;
        end
    endtask

    // Driver: push expected records, then present the bytes.
    task automatic insn(input int n, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic c, input logic sq,
                        input logic pf, input logic ov, input logic [7:0] oa,
                        input string tag, input int gap);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            exp_t       e;
            b = (i == 0) ? b0 : (i == 1) ? b1 : b2;
            e = {b, (i == 0), (i == n - 1), sq, pf, ov, (ov ? oa : 8'h00)};
            expq.push_back(e);
            tagq.push_back(tag);
            put(b, c);
            if (gap > 0) idle(gap);
        end
    endtask

    task automatic do_reset;
        idle(3);
        in_rst = 1'b1;
        rst    = 1'b1;
        idle(2);
        n_cmp++;
        if (ob_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R11: ob_valid during reset got=%b expected=0", ob_valid);
        end
        rst    = 1'b0;
        in_rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish got=hung expected=done");
        report();
    end

    initial begin
        idle(3);
        n_cmp++;
        if (ob_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R11: ob_valid in reset got=%b expected=0", ob_valid);
        end
        rst = 1'b0;
        @(negedge clk);
        in_rst = 1'b0;
        n_cmp++;
        if (ob_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2: ob_valid after reset got=%b expected=0", ob_valid);
        end

        // R1: lengths 1, 2, 3; passing test lets successor run (R3)
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R1", 0);
        insn(2, 8'h98, 8'h55, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R1", 0);
        insn(3, 8'hA9, 8'h20, 8'h30, 1'b1, 0, 0, 0, 8'h00, "R3", 0);
        insn(2, 8'h25, 8'h10, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R3", 0);

        // R3 failing test skips a 3-byte jump whose operands look like opcodes (R1, R6)
        insn(2, 8'h92, 8'h33, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R3", 0);
        insn(3, 8'hAC, 8'hBD, 8'h92, 1'b0, 1, 0, 0, 8'h00, "R6", 0);
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R1", 0);

        // R6: squashed failing test does not skip
        insn(1, 8'h88, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R3", 0);
        insn(1, 8'h89, 8'h00, 8'h00, 1'b0, 1, 0, 0, 8'h00, "R6", 0);
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R6", 0);

        // R4: decrement-and-skip
        insn(1, 8'hC3, 8'h00, 8'h00, 1'b1, 0, 0, 0, 8'h00, "R4", 0);
        insn(2, 8'h9F, 8'h01, 8'h00, 1'b0, 1, 0, 0, 8'h00, "R4", 0);
        insn(1, 8'hC5, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R4", 0);
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b1, 0, 0, 0, 8'h00, "R4", 0);

        // R5: return-with-skip is unconditional
        insn(1, 8'h8D, 8'h00, 8'h00, 1'b1, 0, 0, 0, 8'h00, "R5", 0);
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b0, 1, 0, 0, 8'h00, "R5", 0);
        insn(1, 8'h8D, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R5", 0);
        insn(1, 8'h84, 8'h00, 8'h00, 1'b0, 1, 0, 0, 8'h00, "R5", 0);
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R5", 0);

        // R7, R8: prefix applies to one instruction only
        insn(2, 8'hBD, 8'h47, 8'h00, 1'b0, 0, 1, 0, 8'h00, "R7", 0);
        insn(1, 8'h84, 8'h00, 8'h00, 1'b0, 0, 0, 1, 8'h47, "R7", 0);
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R8", 0);

        // R9: latest prefix wins
        insn(2, 8'hBD, 8'h10, 8'h00, 1'b0, 0, 1, 0, 8'h00, "R9", 0);
        insn(2, 8'hBD, 8'h22, 8'h00, 1'b0, 0, 1, 0, 8'h00, "R9", 0);
        insn(1, 8'h70, 8'h00, 8'h00, 1'b1, 0, 0, 1, 8'h22, "R9", 0);
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R8", 0);

        // R10: skip covers prefix plus its instruction; squashed prefix leaves no override
        insn(2, 8'h93, 8'h05, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R3", 0);
        insn(2, 8'hBD, 8'h60, 8'h00, 1'b0, 1, 1, 0, 8'h00, "R10", 0);
        insn(1, 8'h7A, 8'h00, 8'h00, 1'b0, 1, 0, 0, 8'h00, "R10", 0);
        insn(1, 8'h84, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R10", 0);

        // R10: chain of two prefixes skipped as a unit
        insn(1, 8'h4A, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R3", 0);
        insn(2, 8'hBD, 8'h11, 8'h00, 1'b0, 1, 1, 0, 8'h00, "R10", 0);
        insn(2, 8'hBD, 8'h12, 8'h00, 1'b0, 1, 1, 0, 8'h00, "R10", 0);
        insn(1, 8'h84, 8'h00, 8'h00, 1'b0, 1, 0, 0, 8'h00, "R10", 0);
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R10", 0);

        // R7 + R3: failing test under an override
        insn(2, 8'hBD, 8'h31, 8'h00, 1'b0, 0, 1, 0, 8'h00, "R7", 0);
        insn(1, 8'h82, 8'h00, 8'h00, 1'b0, 0, 0, 1, 8'h31, "R7", 0);
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b0, 1, 0, 0, 8'h00, "R3", 0);
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R8", 0);

        // R12: gaps inside and between instructions
        insn(3, 8'hA9, 8'h40, 8'h50, 1'b0, 0, 0, 0, 8'h00, "R12", 2);
        insn(2, 8'hD2, 8'h77, 8'h00, 1'b0, 1, 0, 0, 8'h00, "R12", 3);
        insn(2, 8'hBD, 8'h5A, 8'h00, 1'b0, 0, 1, 0, 8'h00, "R12", 2);
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b0, 0, 0, 1, 8'h5A, "R12", 0);

        // R11: reset clears pending skip, override and partial instruction
        insn(2, 8'h92, 8'h33, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R11", 0);
        do_reset();
        insn(1, 8'hB8, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R11", 0);
        insn(2, 8'hBD, 8'h55, 8'h00, 1'b0, 0, 1, 0, 8'h00, "R11", 0);
        do_reset();
        insn(1, 8'h84, 8'h00, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R11", 0);
        insn(2, 8'hAC, 8'h12, 8'h00, 1'b0, 0, 0, 0, 8'h00, "R11", 0);
        // the expected last flag of that partial record is wrong by design: fix it
        begin
            exp_t e;
            e = expq.pop_back();
            e.last = 1'b0;
            expq.push_back(e);
        end
        do_reset();
        insn(1, 8'h88, 8'h00, 8'h00, 1'b1, 0, 0, 0, 8'h00, "R11", 0);

        idle(4);
        done = 1'b1;
        n_cmp++;
        if (expq.size() != 0) begin
            n_bad++;
            $display("FAIL R2: records missing got=%0d expected=0", expq.size());
        end
        report();
    end

endmodule